// File: doc/BRIEF.md
# Single-Cycle 16-bit Word-Addressed Processor Core

This block is a single-cycle processor core with 16-bit words, word addressing and eight general-purpose registers. Each instruction is fetched from a separate instruction port, decoded and executed in one clock period. The instruction set covers arithmetic, logic, shifts, loads, stores, two compare-and-branch forms and jump-and-link. It also has two character I/O instructions: a non-blocking keyboard read and a TTY write. Instruction and data memories sit outside the core. The data memory is expected to write on the falling clock edge and to return read data combinationally.

The core uses both clock edges. The register file commits results on the rising edge and the program counter advances on the falling edge. Each instruction therefore owns the whole period from one falling edge to the next.

The keyboard and TTY use valid/ready handshakes. A keyboard transfer completes on a rising edge where `kbd_valid` and `kbd_ready` are both high. `kbd_ready` is high only while a keyboard-read instruction executes, and that instruction never waits: if no character is offered, it still completes. A TTY transfer completes on a rising edge where `tty_valid` and `tty_ready` are both high. While `tty_valid` is high and `tty_ready` is low, the program counter holds and the request stays on the pins. So the TTY consumer can apply back-pressure for any number of cycles.

Top module: `cpu16_core`

## Requirements
- R1: `rst_n` low asynchronously forces the program counter (`imem_addr`) to 0 and clears every register to 0. It does not wait for a clock edge.
- R2: Sequencing and field layout.
  - Instruction fields: opcode in bits 15:12, first source register `rs` in 11:9, second register `rt` in 8:6, R-format destination in 5:3, function code in 2:0, 6-bit immediate in 5:0.
  - A non-control instruction advances the PC by one on the falling edge.
  - Register writes take effect on the rising edge.
- R3: Register 0 always reads as zero, even after an instruction names it as destination.
- R4: Arithmetic and logic.
  - Opcode 0 is R-format with function 0 add, 1 subtract, 2 AND, 3 XOR, and writes `rd` = `rs` op `rt`.
  - Opcode 1 (add-immediate) writes `rt` = `rs` + the sign-extended 6-bit immediate.
- R5: Shifts. Opcode 9 shifts left and opcode 10 shifts right. Each writes `rt` = `rs` shifted by the unsigned 4-bit amount in bits 3:0. The right shift fills with zeros.
- R6: Loads and stores.
  - Opcode 2 (load) drives `dmem_addr` = `rs` + sign-extended immediate and writes the returned word into `rt`.
  - Opcode 3 (store) drives the same address, puts `rt` on `dmem_wdata` and raises `dmem_we`.
  - A store writes no register and raises no I/O request.
- R7: Branches. Opcode 4 branches when `rs` equals `rt`, and opcode 5 branches when `rs` is greater than `rt` as signed numbers. A taken branch sets PC to PC+1+sign-extended immediate; otherwise PC becomes PC+1.
- R8: Opcode 6 (jump-and-link) writes PC+1 into register 7 and loads PC with bits 11:0 of the instruction, zero-extended.
- R9: Keyboard read, opcode 7.
  - `kbd_ready` is high only while this instruction executes.
  - If `kbd_valid` is high, `rt` gets the 7-bit character with all upper bits zero.
  - If `kbd_valid` is low, `rt` gets 0x0080.
  - The instruction completes in one cycle either way.
- R10: TTY write, opcode 8.
  - Raises `tty_valid` with `rs[6:0]` on `tty_data`.
  - While `tty_ready` is low, PC holds and the request stays up.
  - Exactly one transfer occurs, on the rising edge where `tty_ready` is high.
- R11: An opcode above 10, or an R-format function above 3, writes no register, writes no memory, raises no I/O request and advances PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register file on rising edge, PC on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 16 | Instruction word address (the PC) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 16 | Data word address |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes on the falling edge |
| dmem_rdata | input | 16 | Load data at `dmem_addr` |
| kbd_valid | input | 1 | Keyboard character available |
| kbd_data | input | 7 | Keyboard character |
| kbd_ready | output | 1 | Core is taking a character this cycle |
| tty_valid | output | 1 | Character offered to the TTY |
| tty_data | output | 7 | Character for the TTY |
| tty_ready | input | 1 | TTY accepts the character |

## Verification
The hardest state to reach from the ports is a TTY write held under back-pressure for several cycles. In that state the PC must freeze, and the same character must be transferred exactly once when ready returns. The bench withholds `tty_ready` for three cycles at one write and compares the PC and TTY pins against its model on every cycle. It also counts completed TTY transfers. A second case is a signed comparison whose unsigned answer differs: branching when 1 > -3. This needs register values built earlier by sign-extended immediates, so the program constructs them with add-immediate before the branch.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;
  localparam int XLEN    = 16;
  localparam int REG_W   = 3;
  localparam int NREG    = 1 << REG_W;
  localparam int OPC_W   = 4;
  localparam int FN_W    = 3;
  localparam int IMM_W   = 6;
  localparam int SHAMT_W = 4;
  localparam int TGT_W   = 12;
  localparam int CHAR_W  = 7;

  typedef enum logic [OPC_W-1:0] {
    OP_RTYPE = 4'd0,
    OP_ADDI  = 4'd1,
    OP_LOAD  = 4'd2,
    OP_STORE = 4'd3,
    OP_BEQ   = 4'd4,
    OP_BGT   = 4'd5,
    OP_JAL   = 4'd6,
    OP_KIN   = 4'd7,
    OP_TOUT  = 4'd8,
    OP_SHL   = 4'd9,
    OP_SHR   = 4'd10
  } opcode_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_XOR = 3'd3
  } func_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_XOR,
    ALU_SHL,
    ALU_SHR
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU,
    WB_MEM,
    WB_LINK,
    WB_KBD
  } wb_sel_e;

  typedef struct packed {
    logic             reg_we;
    logic [REG_W-1:0] dst;
    alu_op_e          alu_op;
    logic             use_imm;
    wb_sel_e          wb_sel;
    logic             mem_we;
    logic             is_beq;
    logic             is_bgt;
    logic             is_jal;
    logic             is_kin;
    logic             is_tout;
  } ctrl_t;
endpackage

// File: rtl/cpu16_decode.sv
`timescale 1ns/1ps
module cpu16_decode
  import cpu16_pkg::*;
(
  input  logic [XLEN-1:0]    instr,
  output ctrl_t              ctrl,
  output logic [REG_W-1:0]   rs_idx,
  output logic [REG_W-1:0]   rt_idx,
  output logic [XLEN-1:0]    imm_ext,
  output logic [SHAMT_W-1:0] shamt,
  output logic [XLEN-1:0]    jump_tgt
);
  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam int RD_LSB  = RT_LSB - REG_W;

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic [REG_W-1:0] rd_idx;

  assign opc      = instr[XLEN-1:OPC_LSB];
  assign rs_idx   = instr[OPC_LSB-1:RS_LSB];
  assign rt_idx   = instr[RS_LSB-1:RT_LSB];
  assign rd_idx   = instr[RT_LSB-1:RD_LSB];
  assign fn       = instr[FN_W-1:0];
  assign imm_ext  = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign shamt    = instr[SHAMT_W-1:0];
  assign jump_tgt = {{(XLEN-TGT_W){1'b0}}, instr[TGT_W-1:0]};

  always_comb begin
    ctrl         = '0;
    ctrl.alu_op  = ALU_ADD;
    ctrl.wb_sel  = WB_ALU;
    case (opc)
      OP_RTYPE: begin
        ctrl.dst = rd_idx;
        case (fn)
          FN_ADD:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_XOR:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_XOR; end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst     = rt_idx;
        ctrl.use_imm = 1'b1;
      end
      OP_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst     = rt_idx;
        ctrl.use_imm = 1'b1;
        ctrl.wb_sel  = WB_MEM;
      end
      OP_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_BEQ: ctrl.is_beq = 1'b1;
      OP_BGT: ctrl.is_bgt = 1'b1;
      OP_JAL: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = '1;
        ctrl.wb_sel = WB_LINK;
        ctrl.is_jal = 1'b1;
      end
      OP_KIN: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = rt_idx;
        ctrl.wb_sel = WB_KBD;
        ctrl.is_kin = 1'b1;
      end
      OP_TOUT: ctrl.is_tout = 1'b1;
      OP_SHL: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = rt_idx;
        ctrl.alu_op = ALU_SHL;
      end
      OP_SHR: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = rt_idx;
        ctrl.alu_op = ALU_SHR;
      end
      default: ctrl.reg_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
module cpu16_regfile
  import cpu16_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int IDX_W = REG_W,
  localparam int N    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [W-1:0]     rdata_a,
  output logic [W-1:0]     rdata_b
);
  logic [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign q[g] = '0;
    end else begin : g_store
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r <= '0;
        end else if (we && waddr == IDX_W'(g)) begin
          r <= wdata;
        end
      end
      assign q[g] = r;
    end
  end

  // one-hot AND-OR read ports
  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < N; i++) begin
      rdata_a |= q[i] & {W{raddr_a == IDX_W'(i)}};
      rdata_b |= q[i] & {W{raddr_b == IDX_W'(i)}};
    end
  end

  // R2
  rf_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> (raddr_a != $past(waddr)) || (rdata_a == $past(wdata)));

  // R3
  rf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0) |=> (raddr_b != '0) || (rdata_b == '0));
endmodule

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int SH_W = SHAMT_W
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] shamt,
  output logic [W-1:0]    y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_XOR: y = a ^ b;
      ALU_SHL: y = a << shamt;
      ALU_SHR: y = a >> shamt;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/cpu16_pc.sv
`timescale 1ns/1ps
module cpu16_pc
  import cpu16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         take_br,
  input  logic         is_jal,
  input  logic [W-1:0] br_off,
  input  logic [W-1:0] jump_tgt,
  output logic [W-1:0] pc,
  output logic [W-1:0] pc_plus1
);
  logic [W-1:0] pc_next;

  assign pc_plus1 = pc + W'(1);

  always_comb begin
    if (stall)        pc_next = pc;
    else if (is_jal)  pc_next = jump_tgt;
    else if (take_br) pc_next = pc_plus1 + br_off;
    else              pc_next = pc_plus1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  // R2
  pc_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!stall && !take_br && !is_jal) |=> (pc == $past(pc) + W'(1)));

  // R10
  pc_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));

  // R7
  br_target_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (take_br && !stall && !is_jal) |=> (pc == $past(pc) + W'(1) + $past(br_off)));
endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
  import cpu16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [XLEN-1:0]   imem_data,
  output logic [XLEN-1:0]   dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  output logic              dmem_we,
  input  logic [XLEN-1:0]   dmem_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  output logic              kbd_ready,
  output logic              tty_valid,
  output logic [CHAR_W-1:0] tty_data,
  input  logic              tty_ready
);
  localparam logic [XLEN-1:0] KBD_EMPTY = XLEN'(1) << CHAR_W;

  ctrl_t               ctrl;
  logic [REG_W-1:0]    rs_idx, rt_idx;
  logic [XLEN-1:0]     imm_ext, jump_tgt;
  logic [SHAMT_W-1:0]  shamt;
  logic [XLEN-1:0]     rs_val, rt_val, alu_b, alu_y;
  logic [XLEN-1:0]     pc, pc_plus1, kbd_word, rf_wdata;
  logic                take_br, stall;

  cpu16_decode u_dec (
    .instr    (imem_data),
    .ctrl     (ctrl),
    .rs_idx   (rs_idx),
    .rt_idx   (rt_idx),
    .imm_ext  (imm_ext),
    .shamt    (shamt),
    .jump_tgt (jump_tgt)
  );

  cpu16_regfile #(.W(XLEN), .IDX_W(REG_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctrl.reg_we),
    .waddr   (ctrl.dst),
    .wdata   (rf_wdata),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  cpu16_alu #(.W(XLEN), .SH_W(SHAMT_W)) u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (shamt),
    .y     (alu_y)
  );

  assign take_br = (ctrl.is_beq && (rs_val == rt_val)) ||
                   (ctrl.is_bgt && ($signed(rs_val) > $signed(rt_val)));

  assign tty_valid = ctrl.is_tout;
  assign tty_data  = rs_val[CHAR_W-1:0];
  assign stall     = tty_valid && !tty_ready;
  assign kbd_ready = ctrl.is_kin;
  assign kbd_word  = kbd_valid ? {{(XLEN-CHAR_W){1'b0}}, kbd_data} : KBD_EMPTY;

  cpu16_pc #(.W(XLEN)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .take_br  (take_br),
    .is_jal   (ctrl.is_jal),
    .br_off   (imm_ext),
    .jump_tgt (jump_tgt),
    .pc       (pc),
    .pc_plus1 (pc_plus1)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  rf_wdata = dmem_rdata;
      WB_LINK: rf_wdata = pc_plus1;
      WB_KBD:  rf_wdata = kbd_word;
      default: rf_wdata = alu_y;
    endcase
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we;

  // R8
  jal_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.is_jal |-> (ctrl.reg_we && ctrl.dst == '1 && rf_wdata == imem_addr + XLEN'(1)));

  // R6
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (!ctrl.reg_we && !tty_valid && !kbd_ready));

  // R11
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_data[XLEN-1:XLEN-OPC_W] > OPC_W'(OP_SHR)) |->
      (!ctrl.reg_we && !dmem_we && !tty_valid && !kbd_ready));

  // R9
  kbd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_ready && !kbd_valid) |-> (ctrl.reg_we && rf_wdata == KBD_EMPTY));
endmodule

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, kbd_valid, kbd_ready, tty_valid, tty_ready;
  logic [6:0]  kbd_data, tty_data;

  int checks = 0, failures = 0, tty_n = 0;
  bit done = 0;
  logic [15:0] rom [64];
  logic [15:0] ram [64];
  logic [6:0]  tty_log [16];
  logic [15:0] mreg [8];
  logic [15:0] mmem [64];
  logic [15:0] mpc;
  int hold = 0;
  string tag_over = "";

  always #2.5 clk = ~clk;

  cpu16_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .kbd_valid(kbd_valid), .kbd_data(kbd_data),
    .kbd_ready(kbd_ready), .tty_valid(tty_valid), .tty_data(tty_data),
    .tty_ready(tty_ready)
  );

  assign imem_data  = rom[imem_addr[5:0]];
  assign dmem_rdata = ram[dmem_addr[5:0]];

  always @(negedge clk) if (dmem_we) ram[dmem_addr[5:0]] <= dmem_wdata;

  always @(posedge clk)
    if (rst_n && tty_valid && tty_ready) begin
      if (tty_n < 16) tty_log[tty_n] <= tty_data;
      tty_n <= tty_n + 1;
    end

  function automatic logic [15:0] enc_i(int op, int rs, int rt, int imm);
    return {op[3:0], rs[2:0], rt[2:0], imm[5:0]};
  endfunction
  function automatic logic [15:0] enc_r(int fn, int rd, int rs, int rt);
    return {4'd0, rs[2:0], rt[2:0], rd[2:0], fn[2:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_for(logic [3:0] op, logic [2:0] fn, logic [2:0] rs);
    case (op)
      4'd0:       return (fn <= 3'd3) ? "R4" : "R11";
      4'd1:       return "R4";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6:       return "R8";
      4'd7:       return "R9";
      4'd8:       return (rs == 3'd0) ? "R3" : "R10";
      4'd9, 4'd10: return "R5";
      default:    return "R11";
    endcase
  endfunction

  task automatic model_reset();
    mpc = 16'd0;
    hold = 0;
    for (int i = 0; i < 8; i++) mreg[i] = 16'd0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] v);
    if (idx != 3'd0) mreg[idx] = v;
  endtask

  // entered just after a falling edge; returns just after the next one
  task automatic model_cycle();
    logic [15:0] ins, rsv, rtv, imm, npc, addr;
    logic [3:0] op;
    logic [2:0] rs, rt, rd, fn;
    string tag, ptag;
    ins = rom[mpc[5:0]];
    op = ins[15:12]; rs = ins[11:9]; rt = ins[8:6]; rd = ins[5:3]; fn = ins[2:0];
    rsv = mreg[rs]; rtv = mreg[rt];
    imm = {{10{ins[5]}}, ins[5:0]};
    addr = rsv + imm;
    kbd_valid = (mpc == 16'd41);
    kbd_data = 7'h41;
    tty_ready = !(mpc == 16'd43 && hold < 3);
    if (!tty_ready) hold++;
    #1.5;
    tag = (tag_over != "") ? tag_over : tag_for(op, fn, rs);
    ptag = (op == 4'd4 || op == 4'd5 || op == 4'd6 || op == 4'd8) ? tag : "R2";
    chk(ptag, imem_addr, mpc);
    chk(tag, {15'd0, dmem_we}, {15'd0, op == 4'd3});
    if (op == 4'd2 || op == 4'd3) chk(tag, dmem_addr, addr);
    if (op == 4'd3) chk(tag, dmem_wdata, rtv);
    chk(tag, {15'd0, kbd_ready}, {15'd0, op == 4'd7});
    chk(tag, {15'd0, tty_valid}, {15'd0, op == 4'd8});
    if (op == 4'd8) chk(tag, {9'd0, tty_data}, {9'd0, rsv[6:0]});
    npc = mpc + 16'd1;
    case (op)
      4'd0: case (fn)
              3'd0: wr(rd, rsv + rtv);
              3'd1: wr(rd, rsv - rtv);
              3'd2: wr(rd, rsv & rtv);
              3'd3: wr(rd, rsv ^ rtv);
              default: ;
            endcase
      4'd1:  wr(rt, addr);
      4'd2:  wr(rt, mmem[addr[5:0]]);
      4'd3:  mmem[addr[5:0]] = rtv;
      4'd4:  if (rsv == rtv) npc = mpc + 16'd1 + imm;
      4'd5:  if ($signed(rsv) > $signed(rtv)) npc = mpc + 16'd1 + imm;
      4'd6:  begin wr(3'd7, mpc + 16'd1); npc = {4'd0, ins[11:0]}; end
      4'd7:  wr(rt, kbd_valid ? {9'd0, kbd_data} : 16'h0080);
      4'd8:  if (!tty_ready) npc = mpc;
      4'd9:  wr(rt, rsv << ins[3:0]);
      4'd10: wr(rt, rsv >> ins[3:0]);
      default: ;
    endcase
    @(negedge clk);
    mpc = npc;
    #0.5;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      rom[i] = 16'd0; ram[i] = 16'd0; mmem[i] = 16'd0;
    end
    rom[0]  = enc_i(8, 1, 0, 0);      // out r1
    rom[1]  = enc_i(1, 0, 1, 5);      // addi r1,r0,5
    rom[2]  = enc_i(1, 0, 2, -3);     // addi r2,r0,-3
    rom[3]  = enc_r(0, 3, 1, 2);      // add r3
    rom[4]  = enc_r(1, 4, 2, 1);      // sub r4
    rom[5]  = enc_r(2, 5, 1, 2);      // and r5
    rom[6]  = enc_i(3, 0, 5, 3);      // sw r5,3(r0)
    rom[7]  = enc_r(3, 5, 5, 2);      // xor r5
    rom[8]  = enc_i(3, 0, 5, 5);      // sw r5,5(r0)
    rom[9]  = enc_i(3, 0, 3, 6);      // sw r3,6(r0)
    rom[10] = enc_i(1, 0, 0, 7);      // addi r0,r0,7
    rom[11] = enc_i(8, 0, 0, 0);      // out r0
    rom[12] = enc_i(9, 1, 3, 12);     // sll r3,r1,12
    rom[13] = enc_i(10, 4, 4, 15);    // srl r4,r4,15
    rom[14] = enc_i(3, 1, 3, 2);      // sw r3,2(r1)
    rom[15] = enc_i(3, 1, 4, -1);     // sw r4,-1(r1)
    rom[16] = enc_i(2, 1, 6, 2);      // lw r6,2(r1)
    rom[17] = enc_i(3, 0, 6, 0);      // sw r6,0(r0)
    rom[18] = enc_i(4, 1, 1, 2);      // beq taken
    rom[19] = enc_i(8, 1, 0, 0);
    rom[20] = enc_i(8, 1, 0, 0);
    rom[21] = enc_i(5, 4, 2, 1);      // bgt 1 > -3 taken
    rom[22] = enc_i(8, 2, 0, 0);
    rom[23] = enc_i(5, 2, 4, 5);      // bgt not taken
    rom[24] = enc_i(4, 1, 2, 5);      // beq not taken
    rom[25] = enc_i(8, 1, 0, 0);      // out r1
    rom[26] = {4'd6, 12'd40};         // jal 40
    rom[40] = enc_i(3, 0, 7, 1);      // sw r7,1(r0)
    rom[41] = enc_i(7, 0, 1, 0);      // in r1 (char offered)
    rom[42] = enc_i(7, 0, 2, 0);      // in r2 (none)
    rom[43] = enc_i(8, 1, 0, 0);      // out r1, back-pressured
    rom[44] = enc_i(8, 2, 0, 0);      // out r2
    rom[45] = 16'hF000;               // undefined opcode
    rom[46] = enc_i(4, 0, 0, -1);     // self loop

    kbd_valid = 1'b0; kbd_data = 7'd0; tty_ready = 1'b1;
    #1;
    chk("R1", imem_addr, 16'd0);
    @(negedge clk); @(negedge clk); #0.5;
    rst_n = 1'b1;
    model_reset();
    repeat (80) model_cycle();

    chk("R10", 16'(tty_n), 16'd5);
    chk("R10", {9'd0, tty_log[2]}, 16'd5);
    chk("R10", {9'd0, tty_log[3]}, 16'h0041);
    chk("R9",  {9'd0, tty_log[4]}, 16'd0);
    chk("R3",  {9'd0, tty_log[1]}, 16'd0);
    chk("R4",  ram[3], 16'h0005);
    chk("R4",  ram[5], 16'hFFF8);
    chk("R4",  ram[6], 16'h0002);
    chk("R5",  ram[4], 16'h0001);
    chk("R6",  ram[7], 16'h5000);
    chk("R6",  ram[0], 16'h5000);
    chk("R8",  ram[1], 16'd27);

    // asynchronous reset in the middle of a cycle
    #0.7;
    rst_n = 1'b0;
    #0.3;
    chk("R1", imem_addr, 16'd0);
    @(negedge clk); #0.5;
    rst_n = 1'b1;
    model_reset();
    tag_over = "R1";
    model_cycle();
    tag_over = "";
    repeat (3) model_cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule